// File: doc/BRIEF.md
# Two-Plane Monochrome Cursor Overlay

This block lays a 64x64 pixel cursor over a stream of 32-bit display pixels. The cursor image sits in video memory as 64 rows of 16 bytes. In each row the first eight bytes form a mask plane and the last eight bytes form a pattern plane. Each pixel takes one bit from each plane. The two bits select one of four results: the pixel passes through, the pixel is bit-inverted, or the pixel is replaced by one of two programmed 24-bit colours.

The display timing logic drives the block in three steps. During horizontal blanking it requests the cursor row for the next scanline with a fetch request; the block reads that row through a simple read port into a fetch buffer. At the start of the scanline a line-start pulse copies the fetch buffer into the active buffer. Pixels then stream through at one per clock, each with its column number, and each output pixel appears one cycle after its input.

Position, image offset and colours are shadowed. They are loaded at a frame-start pulse, but only while the lock input is low. The enable, display base, horizontal width and vertical end inputs are used as they are, with no shadowing.

Top module: `cursor_overlay`

## Requirements
- R1: A fetch for line L reads 16 bytes from consecutive addresses. The first address is `disp_base[26:0]` plus the shadowed image offset plus (L-Y)*16, wrapping at 27 bits. The bytes are read in 16/BEAT_BYTES beats, with the byte at the lowest address in the lowest lane of a beat. `mem_rd_en` is high only while `fetch_busy` is high, and each beat's address is the previous one plus BEAT_BYTES.
- R2: Cursor column c (0 to 63) uses bit 7-(c mod 8) of byte c/8 as its mask bit and the same bit of byte 8+c/8 as its pattern bit. Bits are used MSB first, from left to right.
- R3: When the mask bit is 1 and the pattern bit is 1, the output is the bitwise complement of the input pixel.
- R4: When the mask bit is 1 and the pattern bit is 0, the output equals the input pixel.
- R5: When the mask bit is 0, the output is {colour1, 8'hFF} if the pattern bit is 1, and {colour0, 8'hFF} if the pattern bit is 0.
- R6: The cursor X position is taken from `cfg_pos[29:16]` and the Y position from `cfg_pos[11:0]`. All other bits of `cfg_pos` are ignored.
- R7: Only bits 26:4 of `cfg_offset` take part in addressing, so the cursor image is always 16-byte aligned.
- R8: While `cfg_enable` is low, every output pixel equals its input pixel.
- R9: For a line L below Y, at or beyond Y+64, or greater than `disp_vtotal[27:16]`, no pixel of that line is altered. Line Y+63, and a line equal to the vertical end value, are still drawn.
- R10: A pixel whose column is at or beyond (`disp_htotal[26:16]`+1)*8 passes through unchanged, so the cursor never wraps onto the next line.
- R11: Position, offset and colours are loaded into the shadow registers on `frame_start` only while `cfg_lock` is low. While the lock is high, the values already loaded stay in effect.
- R12: `pix_out` and `pix_out_valid` follow `pix_in` and `pix_valid` with exactly one clock of latency. Pixels outside the cursor columns pass through unchanged.
- R13: After reset, `pix_out_valid`, `mem_rd_en` and `fetch_busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Cursor display enable |
| cfg_lock | input | 1 | Blocks shadow loading while high |
| cfg_pos | input | 32 | Position: X in bits 29:16, Y in bits 11:0 |
| cfg_offset | input | 32 | Cursor image offset in bytes |
| cfg_colour0 | input | 24 | Colour used when both plane bits are 0 |
| cfg_colour1 | input | 24 | Colour used when mask is 0 and pattern is 1 |
| disp_base | input | 32 | Display base offset |
| disp_htotal | input | 32 | Bits 26:16 hold horizontal display width/8 - 1 |
| disp_vtotal | input | 32 | Bits 27:16 hold the last displayed line |
| frame_start | input | 1 | Frame boundary pulse that loads the shadow registers |
| fetch_req | input | 1 | Request to fetch the cursor row for `fetch_line` |
| fetch_line | input | 12 | Scanline number to fetch for |
| line_start | input | 1 | Copies the fetch buffer into the active buffer |
| fetch_busy | output | 1 | A fetch is in progress |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_rd_data | input | 8*BEAT_BYTES | Read data, valid one cycle after the strobe |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_x | input | 14 | Column of the input pixel |
| pix_in | input | 32 | Input pixel |
| pix_out_valid | output | 1 | Output pixel qualifier |
| pix_out | output | 32 | Output pixel |

## Verification
Some rules can be checked on every clock cycle without knowing the image, and the assertions cover these. They check that reads happen only inside a fetch and step through consecutive addresses, that the output valid follows the input valid by one cycle, and that a pixel passes through unchanged when the cursor is disabled or the column lies at or beyond the horizontal end. Other behaviour depends on the image held in memory and on how a whole frame is sequenced, so only the bench scenarios can show it. This covers the four-way decode for each bit and its MSB-first order, the clipping at the window edges and the vertical end, the alignment of the fetch address, and shadow loading being held off by the lock and resumed after release.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
   localparam int CUR_DIM     = 64;
   localparam int ROW_BYTES   = 16;
   localparam int PLANE_BYTES = 8;
   localparam int PIX_W       = 32;
   localparam int COL_W       = 24;
   localparam int X_W         = 14;
   localparam int Y_W         = 12;

   function automatic logic [PIX_W-1:0] colour_word(input logic [COL_W-1:0] c);
      return {c, 8'hFF};
   endfunction
endpackage

// File: rtl/cursor_fetch.sv
module cursor_fetch
   import cursor_pkg::*;
#(
   parameter int ADDR_W     = 27,
   parameter int BEAT_BYTES = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req,
   input  logic [Y_W-1:0]            line,
   input  logic [Y_W-1:0]            cur_y,
   input  logic [Y_W-1:0]            vend,
   input  logic [ADDR_W-1:0]         img_base,
   output logic                      busy,
   output logic                      hit,
   output logic [8*ROW_BYTES-1:0]    row_bytes,
   output logic                      mem_rd_en,
   output logic [ADDR_W-1:0]         mem_addr,
   input  logic [8*BEAT_BYTES-1:0]   mem_rd_data
);
   localparam int BEATS  = ROW_BYTES / BEAT_BYTES;
   localparam int CNT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam int LANE_W = 8 * BEAT_BYTES;

   logic [Y_W-1:0]   row_diff;
   logic             in_win;
   logic             issuing;
   logic [CNT_W-1:0] beat_q;
   logic             pend_q;
   logic [CNT_W-1:0] pend_idx_q;
   logic             last_issue;

   assign row_diff   = line - cur_y;
   assign in_win     = (line >= cur_y) && (row_diff < Y_W'(CUR_DIM)) && (line <= vend);
   assign mem_rd_en  = issuing;
   assign last_issue = (beat_q == CNT_W'(BEATS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         hit        <= 1'b0;
         issuing    <= 1'b0;
         beat_q     <= '0;
         pend_q     <= 1'b0;
         pend_idx_q <= '0;
         mem_addr   <= '0;
         row_bytes  <= '0;
      end else begin
         pend_q     <= issuing;
         pend_idx_q <= beat_q;
         if (req && !busy) begin
            hit <= in_win;
            if (in_win) begin
               busy     <= 1'b1;
               issuing  <= 1'b1;
               beat_q   <= '0;
               mem_addr <= img_base + {{(ADDR_W-10){1'b0}}, row_diff[5:0], 4'b0000};
            end
         end
         if (issuing) begin
            mem_addr <= mem_addr + ADDR_W'(BEAT_BYTES);
            beat_q   <= beat_q + 1'b1;
            if (last_issue) issuing <= 1'b0;
         end
         if (pend_q) begin
            row_bytes[int'(pend_idx_q)*LANE_W +: LANE_W] <= mem_rd_data;
            if (pend_idx_q == CNT_W'(BEATS - 1)) busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/cursor_pixel.sv
module cursor_pixel
   import cursor_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   valid_in,
   input  logic [X_W-1:0]         x,
   input  logic [PIX_W-1:0]       pin,
   input  logic                   en,
   input  logic                   line_hit,
   input  logic [X_W-1:0]         cur_x,
   input  logic [X_W:0]           hwidth,
   input  logic [8*ROW_BYTES-1:0] row_bytes,
   input  logic [COL_W-1:0]       colour0,
   input  logic [COL_W-1:0]       colour1,
   output logic                   valid_out,
   output logic [PIX_W-1:0]       pout
);
   logic [X_W-1:0]   col_full;
   logic [5:0]       col;
   logic             in_x;
   logic             mask_bit;
   logic             pat_bit;
   logic [PIX_W-1:0] mixed;

   assign col_full = x - cur_x;
   assign col      = col_full[5:0];
   assign in_x     = (x >= cur_x) && (col_full < X_W'(CUR_DIM)) && ({1'b0, x} < hwidth);
   assign mask_bit = row_bytes[{1'b0, col[5:3], ~col[2:0]}];
   assign pat_bit  = row_bytes[{1'b1, col[5:3], ~col[2:0]}];

   always_comb begin
      if (!(en && line_hit && in_x))      mixed = pin;
      else if (mask_bit && pat_bit)       mixed = ~pin;
      else if (mask_bit)                  mixed = pin;
      else if (pat_bit)                   mixed = colour_word(colour1);
      else                                mixed = colour_word(colour0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_out <= 1'b0;
         pout      <= '0;
      end else begin
         valid_out <= valid_in;
         pout      <= mixed;
      end
   end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
   import cursor_pkg::*;
#(
   parameter int ADDR_W     = 27,
   parameter int BEAT_BYTES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_enable,
   input  logic                    cfg_lock,
   input  logic [31:0]             cfg_pos,
   input  logic [31:0]             cfg_offset,
   input  logic [23:0]             cfg_colour0,
   input  logic [23:0]             cfg_colour1,
   input  logic [31:0]             disp_base,
   input  logic [31:0]             disp_htotal,
   input  logic [31:0]             disp_vtotal,
   input  logic                    frame_start,
   input  logic                    fetch_req,
   input  logic [11:0]             fetch_line,
   input  logic                    line_start,
   output logic                    fetch_busy,
   output logic                    mem_rd_en,
   output logic [ADDR_W-1:0]       mem_addr,
   input  logic [8*BEAT_BYTES-1:0] mem_rd_data,
   input  logic                    pix_valid,
   input  logic [13:0]             pix_x,
   input  logic [31:0]             pix_in,
   output logic                    pix_out_valid,
   output logic [31:0]             pix_out
);
   if (!(BEAT_BYTES == 1 || BEAT_BYTES == 2 || BEAT_BYTES == 4 ||
         BEAT_BYTES == 8 || BEAT_BYTES == 16)) begin : g_bad_beat
      $error("BEAT_BYTES must be a power of two from 1 to 16");
   end
   if (ADDR_W < 10 || ADDR_W > 27) begin : g_bad_addr
      $error("ADDR_W must lie between 10 and 27");
   end

   logic [X_W-1:0]         sh_x;
   logic [Y_W-1:0]         sh_y;
   logic [ADDR_W-5:0]      sh_off;
   logic [COL_W-1:0]       sh_c0;
   logic [COL_W-1:0]       sh_c1;
   logic [ADDR_W-1:0]      img_base;
   logic [X_W:0]           hwidth;
   logic                   f_hit;
   logic [8*ROW_BYTES-1:0] f_bytes;
   logic                   act_hit;
   logic [8*ROW_BYTES-1:0] act_bytes;

   assign img_base = disp_base[ADDR_W-1:0] + {sh_off, 4'b0000};
   assign hwidth   = {disp_htotal[26:16] + 11'd1, 3'b000} | {X_W+1{1'b0}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_x      <= '0;
         sh_y      <= '0;
         sh_off    <= '0;
         sh_c0     <= '0;
         sh_c1     <= '0;
         act_hit   <= 1'b0;
         act_bytes <= '0;
      end else begin
         if (frame_start && !cfg_lock) begin
            sh_x   <= cfg_pos[29:16];
            sh_y   <= cfg_pos[11:0];
            sh_off <= cfg_offset[ADDR_W-1:4];
            sh_c0  <= cfg_colour0;
            sh_c1  <= cfg_colour1;
         end
         if (line_start) begin
            act_hit   <= f_hit;
            act_bytes <= f_bytes;
         end
      end
   end

   cursor_fetch #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_fetch (
      .clk(clk), .rst_n(rst_n), .req(fetch_req), .line(fetch_line),
      .cur_y(sh_y), .vend(disp_vtotal[27:16]), .img_base(img_base),
      .busy(fetch_busy), .hit(f_hit), .row_bytes(f_bytes),
      .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data)
   );

   cursor_pixel u_pixel (
      .clk(clk), .rst_n(rst_n), .valid_in(pix_valid), .x(pix_x), .pin(pix_in),
      .en(cfg_enable), .line_hit(act_hit), .cur_x(sh_x), .hwidth(hwidth),
      .row_bytes(act_bytes), .colour0(sh_c0), .colour1(sh_c1),
      .valid_out(pix_out_valid), .pout(pix_out)
   );
endmodule

module cursor_overlay_chk #(
   parameter int ADDR_W     = 27,
   parameter int BEAT_BYTES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_enable,
   input logic [31:0]       disp_htotal,
   input logic              fetch_busy,
   input logic              mem_rd_en,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              pix_valid,
   input logic [13:0]       pix_x,
   input logic [31:0]       pix_in,
   input logic              pix_out_valid,
   input logic [31:0]       pix_out
);
   logic [14:0] width_chk;
   assign width_chk = {disp_htotal[26:16] + 11'd1, 3'b000} | 15'd0;

   AST_READ_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> fetch_busy); // R1
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en && $past(mem_rd_en) |-> mem_addr == $past(mem_addr) + ADDR_W'(BEAT_BYTES)); // R1
   AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> pix_out_valid); // R12
   AST_NO_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> !pix_out_valid); // R12
   AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid && !cfg_enable |=> pix_out == $past(pix_in)); // R8
   AST_CLIP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid && ({1'b0, pix_x} >= width_chk) |=> pix_out == $past(pix_in)); // R10
endmodule

bind cursor_overlay cursor_overlay_chk #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .disp_htotal(disp_htotal),
   .fetch_busy(fetch_busy), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
   .pix_valid(pix_valid), .pix_x(pix_x), .pix_in(pix_in),
   .pix_out_valid(pix_out_valid), .pix_out(pix_out)
);

// File: tb/sim_cursor_overlay.sv
module sim_cursor_overlay;
   localparam int ADDR_W = 27;
   localparam int BB     = 4;
   localparam logic [31:0] C0W = 32'h123456FF;
   localparam logic [31:0] C1W = 32'hABCDEFFF;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_enable = 1'b1, cfg_lock = 1'b0;
   logic [31:0] cfg_pos = 32'hC064_F014, cfg_offset = 32'h0000_010F;
   logic [23:0] cfg_colour0 = 24'h123456, cfg_colour1 = 24'hABCDEF;
   logic [31:0] disp_base = 32'h40, disp_htotal = 32'd99 << 16, disp_vtotal = 32'd479 << 16;
   logic frame_start = 0, fetch_req = 0, line_start = 0, pix_valid = 0;
   logic [11:0] fetch_line = '0;
   logic [13:0] pix_x = '0;
   logic [31:0] pix_in = '0;
   logic fetch_busy, mem_rd_en, pix_out_valid;
   logic [ADDR_W-1:0] mem_addr;
   logic [8*BB-1:0] mem_rd_data;
   logic [31:0] pix_out;
   logic [7:0] mem [0:2047];
   logic [ADDR_W-1:0] first_addr;
   int checks = 0, fails = 0, cycles = 0;

   always #5 clk = ~clk;

   always_ff @(posedge clk)
      if (mem_rd_en)
         for (int k = 0; k < BB; k++) mem_rd_data[8*k +: 8] <= mem[mem_addr[10:0] + 11'(k)];

   cursor_overlay #(.ADDR_W(ADDR_W), .BEAT_BYTES(BB)) u0 (.*);

   // {x, pixel in, expected pixel out} for line 22 (cursor row 2)
   localparam logic [77:0] VEC [10] = '{
      {14'd99,  32'hA5A5A5A5, 32'hA5A5A5A5},
      {14'd100, 32'h11223344, 32'hEEDDCCBB},
      {14'd101, 32'h00FF00FF, 32'hFF00FF00},
      {14'd102, 32'hCAFEF00D, 32'hCAFEF00D},
      {14'd104, 32'h01010101, C1W},
      {14'd105, 32'h02020202, C1W},
      {14'd106, 32'h03030303, C0W},
      {14'd110, 32'h0BADBEEF, 32'h0BADBEEF},
      {14'd163, 32'h77777777, C1W},
      {14'd164, 32'h88888888, 32'h88888888}};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pixel(input logic [13:0] x, input logic [31:0] pin, input logic [31:0] exp,
                        input string req);
      @(negedge clk); pix_valid = 1; pix_x = x; pix_in = pin;
      @(negedge clk); pix_valid = 0;
      check(req, pix_out, exp);
      check("R12 valid", {31'd0, pix_out_valid}, 32'd1);
   endtask

   task automatic frame();
      @(negedge clk); frame_start = 1;
      @(negedge clk); frame_start = 0;
   endtask

   task automatic load_line(input logic [11:0] l);
      @(negedge clk); fetch_req = 1; fetch_line = l;
      @(negedge clk); fetch_req = 0;
      first_addr = mem_addr;
      while (fetch_busy) @(negedge clk);
      line_start = 1;
      @(negedge clk); line_start = 0;
   endtask

   initial begin
      for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
      mem[11'h160] = 8'hF0;
      for (int i = 1; i < 7; i++) mem[11'h160 + 11'(i)] = 8'hFF;
      mem[11'h168] = 8'hCC;
      mem[11'h16F] = 8'hFF;
      repeat (3) @(negedge clk);
      // R13 reset state
      check("R13 valid", {31'd0, pix_out_valid}, 32'd0);
      check("R13 rd_en", {31'd0, mem_rd_en}, 32'd0);
      check("R13 busy", {31'd0, fetch_busy}, 32'd0);
      rst_n = 1;
      frame();
      load_line(12'd22);
      check("R1 R7 fetch address", 32'(first_addr), 32'h160);
      // R2 R3 R4 R5 R6 R12 via table
      for (int v = 0; v < 10; v++)
         pixel(VEC[v][77:64], VEC[v][63:32], VEC[v][31:0], "R2 R3 R4 R5 R6 R12 table");
      // R10 clip at width 160
      disp_htotal = 32'd19 << 16;
      pixel(14'd159, 32'h5, C1W, "R10 last column drawn");
      pixel(14'd160, 32'h6, 32'h6, "R10 clipped");
      disp_htotal = 32'd99 << 16;
      // R8 enable
      cfg_enable = 0;
      pixel(14'd104, 32'h7, 32'h7, "R8 disabled");
      cfg_enable = 1;
      // R9 vertical window
      load_line(12'd19);
      pixel(14'd104, 32'h8, 32'h8, "R9 above window");
      load_line(12'd84);
      pixel(14'd104, 32'h9, 32'h9, "R9 below window");
      load_line(12'd83);
      pixel(14'd104, 32'hA, C0W, "R9 last row drawn");
      disp_vtotal = 32'd82 << 16;
      load_line(12'd83);
      pixel(14'd104, 32'hB, 32'hB, "R9 beyond vertical end");
      load_line(12'd82);
      pixel(14'd104, 32'hC, C0W, "R9 at vertical end");
      disp_vtotal = 32'd479 << 16;
      // R11 lock holds shadow values
      cfg_lock = 1; cfg_pos = 32'h0000_0014; cfg_colour1 = 24'h00FF00;
      frame();
      load_line(12'd22);
      pixel(14'd104, 32'hD, C1W, "R11 locked keeps position and colour");
      cfg_lock = 0;
      frame();
      load_line(12'd22);
      pixel(14'd104, 32'hE, 32'hE, "R11 new position outside");
      pixel(14'd4, 32'hF, 32'h00FF00FF, "R11 new position and colour");
      finish_run();
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected<100000", cycles);
         finish_run();
      end
   end
endmodule